// File: doc/BRIEF.md
# Two-Digit BCD Up/Down Counter with Display Select

This block keeps a two-digit decimal count that moves by one on every accepted count strobe. The strobe comes from a rate divider outside the block. A single-cycle toggle request reverses the counting direction. While the hold input is high, strobes are ignored and the count is frozen. Each digit is stored as a 4-bit BCD nibble, and the digits are chained so that a carry or borrow passes upward in the same clock edge.

A view-select level chooses what the two output nibbles carry: either the count, or the rate divider's ratio (high nibble) and running count (low nibble). Each chosen nibble is decoded to seven segments and drives two display positions. The segment outputs are registered, so they follow their sources one clock later.

Top module: `bcd_updown_display`

## Requirements
- R1: With `rst` high on a clock edge, the count becomes 00 and `dir_down` becomes 0 (up). Every display position shows the pattern for 0 (0x3F) from that edge onward until the next update.
- R2: Counting up, each accepted strobe adds one to the count in the edge that samples it. Both `count_bcd` nibbles always hold 0 to 9, and 99 wraps to 00.
- R3: Counting up, the high digit increments exactly when the low digit passes from 9 to 0. This holds whether the high digit is odd or even.
- R4: Counting down, each accepted strobe subtracts one. The low digit passes from 0 to 9 and borrows from the high digit, and 00 wraps to 99.
- R5: `dir_down` is 0 for up and 1 for down. A cycle with `dir_tgl` high inverts it at that edge. A toggle without a strobe leaves the count unchanged.
- R6: When `dir_tgl` and an accepted strobe fall in the same cycle, that strobe still steps in the old direction. The new direction applies from the next strobe.
- R7: While `pause` is high, strobes do not change the count, but `dir_tgl` still inverts the direction.
- R8: With `show_rate` low, digit slot 1 shows the high count digit and slot 0 shows the low count digit. With `show_rate` high, slot 1 shows `rate_ratio` and slot 0 shows `rate_count`. The view choice never alters the count.
- R9: The segment bus holds 7 bits per display position, with position p at bits [7p+6:7p]. Positions 2k and 2k+1 both show slot k. The bits are active high, with bit 0 = a up to bit 6 = g. Values 0 to 15 show 0-9 and A, b, C, d, E, F. The 2 lights a, b, d, e and g but not f. Each position reflects the slot value and view select sampled at the previous edge.
- R10: In a cycle with no strobe, the count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_stb | input | 1 | Count strobe, one step per high cycle |
| dir_tgl | input | 1 | Direction toggle request, one flip per high cycle |
| pause | input | 1 | Hold level; strobes ignored while high |
| show_rate | input | 1 | View select: 0 count, 1 divider ratio and count |
| rate_ratio | input | RATIO_W (4) | Rate divider ratio, shown in slot 1 |
| rate_count | input | PCNT_W (4) | Rate divider running count, shown in slot 0 |
| count_bcd | output | 4*NUM_DIGITS (8) | Count as BCD, high digit in upper nibble |
| dir_down | output | 1 | Current direction, 1 = down |
| seg_bus | output | 14*NUM_DIGITS (28) | Segment patterns, 7 bits per display position |

## Verification
The collision that matters is a direction toggle landing in the same cycle as a count strobe. The step must use the old direction while the direction register flips, and the same pairing is repeated under pause, where only the flip may occur. The bench drives runs of coincident toggle and strobe pairs, including at the 00 and 99 boundaries. After each edge it compares the count and the direction against an arithmetic model that applies the step before the flip. A second overlap, a view change in the same cycle as a step, is judged through the segment bus. That bus must show the pre-edge value of whichever source was selected.

// File: rtl/bcd_disp_pkg.sv
package bcd_disp_pkg;

  localparam int NIB_W = 4;
  localparam int SEG_W = 7;
  localparam int DISPS_PER_SLOT = 2;

  typedef logic [NIB_W-1:0] nibble_t;
  typedef logic [SEG_W-1:0] seg_t;

  // Active-high segments, bit 0 = a ... bit 6 = g.
  function automatic seg_t hex_to_seg(input nibble_t v);
    seg_t s;
    case (v)
      4'h0: s = 7'b0111111;
      4'h1: s = 7'b0000110;
      4'h2: s = 7'b1011011;  // f stays dark
      4'h3: s = 7'b1001111;
      4'h4: s = 7'b1100110;
      4'h5: s = 7'b1101101;
      4'h6: s = 7'b1111101;
      4'h7: s = 7'b0000111;
      4'h8: s = 7'b1111111;
      4'h9: s = 7'b1101111;
      4'hA: s = 7'b1110111;
      4'hB: s = 7'b1111100;
      4'hC: s = 7'b0111001;
      4'hD: s = 7'b1011110;
      4'hE: s = 7'b1111001;
      default: s = 7'b1110001;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/bcd_digit_cell.sv
module bcd_digit_cell
  import bcd_disp_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    step,
  input  logic    down,
  output nibble_t value
);

  always_ff @(posedge clk) begin
    if (rst) begin
      value <= '0;
    end else if (step) begin
      if (down) begin
        value <= (value == 4'd0) ? 4'd9 : value - 4'd1;
      end else begin
        value <= (value == 4'd9) ? 4'd0 : value + 4'd1;
      end
    end
  end

endmodule

// File: rtl/bcd_chain.sv
module bcd_chain
  import bcd_disp_pkg::*;
#(
  parameter int NUM_DIGITS = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        advance,
  input  logic                        down,
  output logic [NUM_DIGITS*NIB_W-1:0] value
);

  logic [NUM_DIGITS-1:0] step;

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
    if (i == 0) begin : g_first
      assign step[i] = advance;
    end else begin : g_next
      // Step the higher digit when the lower one sits at its turnover value.
      assign step[i] = step[i-1] &
        (down ? (value[(i-1)*NIB_W +: NIB_W] == 4'd0)
              : (value[(i-1)*NIB_W +: NIB_W] == 4'd9));
    end

    bcd_digit_cell u_cell (
      .clk   (clk),
      .rst   (rst),
      .step  (step[i]),
      .down  (down),
      .value (value[i*NIB_W +: NIB_W])
    );
  end

endmodule

// File: rtl/seg_display_bank.sv
module seg_display_bank
  import bcd_disp_pkg::*;
#(
  parameter int NUM_DIGITS = 2
) (
  input  logic                                       clk,
  input  logic                                       rst,
  input  logic                                       show_alt,
  input  logic [NUM_DIGITS*NIB_W-1:0]                main_val,
  input  logic [NUM_DIGITS*NIB_W-1:0]                alt_val,
  output logic [NUM_DIGITS*DISPS_PER_SLOT*SEG_W-1:0] seg_bus
);

  localparam int NUM_DISP = NUM_DIGITS * DISPS_PER_SLOT;

  for (genvar p = 0; p < NUM_DISP; p++) begin : g_disp
    localparam int SLOT = p / DISPS_PER_SLOT;
    nibble_t shown;

    assign shown = show_alt ? alt_val[SLOT*NIB_W +: NIB_W]
                            : main_val[SLOT*NIB_W +: NIB_W];

    always_ff @(posedge clk) begin
      if (rst) begin
        seg_bus[p*SEG_W +: SEG_W] <= hex_to_seg(4'd0);
      end else begin
        seg_bus[p*SEG_W +: SEG_W] <= hex_to_seg(shown);
      end
    end
  end

endmodule

// File: rtl/bcd_updown_display.sv
module bcd_updown_display
  import bcd_disp_pkg::*;
#(
  parameter int NUM_DIGITS = 2,
  parameter int RATIO_W    = 4,
  parameter int PCNT_W     = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cnt_stb,
  input  logic                          dir_tgl,
  input  logic                          pause,
  input  logic                          show_rate,
  input  logic [RATIO_W-1:0]            rate_ratio,
  input  logic [PCNT_W-1:0]             rate_count,
  output logic [NUM_DIGITS*4-1:0]       count_bcd,
  output logic                          dir_down,
  output logic [NUM_DIGITS*2*7-1:0]     seg_bus
);

  localparam int VAL_W = NUM_DIGITS * NIB_W;

  logic             advance;
  logic [VAL_W-1:0] alt_val;

  assign advance = cnt_stb & ~pause;

  // Direction register: a toggle in the strobe cycle only affects later steps,
  // because the chain reads the registered value.
  always_ff @(posedge clk) begin
    if (rst) begin
      dir_down <= 1'b0;
    end else if (dir_tgl) begin
      dir_down <= ~dir_down;
    end
  end

  always_comb begin
    alt_val = '0;
    alt_val[0 +: NIB_W]     = NIB_W'(rate_count);
    alt_val[NIB_W +: NIB_W] = NIB_W'(rate_ratio);
  end

  bcd_chain #(
    .NUM_DIGITS (NUM_DIGITS)
  ) u_chain (
    .clk     (clk),
    .rst     (rst),
    .advance (advance),
    .down    (dir_down),
    .value   (count_bcd)
  );

  seg_display_bank #(
    .NUM_DIGITS (NUM_DIGITS)
  ) u_disp (
    .clk      (clk),
    .rst      (rst),
    .show_alt (show_rate),
    .main_val (count_bcd),
    .alt_val  (alt_val),
    .seg_bus  (seg_bus)
  );

endmodule

// File: rtl/bcd_updown_checker.sv
module bcd_updown_checker #(
  parameter int NUM_DIGITS = 2
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    cnt_stb,
  input logic                    dir_tgl,
  input logic                    pause,
  input logic [NUM_DIGITS*4-1:0] count_bcd,
  input logic                    dir_down
);

  // R2: digits stay decimal
  assert_digits_bcd_R2: assert property (@(posedge clk) disable iff (rst)
    (count_bcd[3:0] <= 4'd9) && (count_bcd[7:4] <= 4'd9));

  // R10: no strobe, no change
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !cnt_stb |=> $stable(count_bcd));

  // R7: pause freezes the count
  assert_pause_hold_R7: assert property (@(posedge clk) disable iff (rst)
    pause |=> $stable(count_bcd));

  // R5: each toggle inverts the direction
  assert_toggle_flip_R5: assert property (@(posedge clk) disable iff (rst)
    dir_tgl |=> (dir_down != $past(dir_down)));

  // R3: low-digit rollover upward carries into the high digit
  assert_carry_up_R3: assert property (@(posedge clk) disable iff (rst)
    (cnt_stb && !pause && !dir_down && count_bcd[3:0] == 4'd9 && count_bcd[7:4] != 4'd9)
    |=> (count_bcd[7:4] == $past(count_bcd[7:4]) + 4'd1) && (count_bcd[3:0] == 4'd0));

  // R4: 00 counting down wraps to 99
  assert_borrow_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (cnt_stb && !pause && dir_down && count_bcd[7:0] == 8'h00)
    |=> count_bcd[7:0] == 8'h99);

endmodule

bind bcd_updown_display bcd_updown_checker #(
  .NUM_DIGITS (NUM_DIGITS)
) u_checker (
  .clk       (clk),
  .rst       (rst),
  .cnt_stb   (cnt_stb),
  .dir_tgl   (dir_tgl),
  .pause     (pause),
  .count_bcd (count_bcd),
  .dir_down  (dir_down)
);

// File: tb/sim_bcd_updown_display.sv
module sim_bcd_updown_display;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cnt_stb = 1'b0;
  logic        dir_tgl = 1'b0;
  logic        pause = 1'b0;
  logic        show_rate = 1'b0;
  logic [3:0]  rate_ratio = 4'd0;
  logic [3:0]  rate_count = 4'd0;
  logic [7:0]  count_bcd;
  logic        dir_down;
  logic [27:0] seg_bus;

  int checks = 0;
  int failures = 0;
  int ref_val = 0;
  bit ref_down = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bcd_updown_display u0 (
    .clk        (clk),
    .rst        (rst),
    .cnt_stb    (cnt_stb),
    .dir_tgl    (dir_tgl),
    .pause      (pause),
    .show_rate  (show_rate),
    .rate_ratio (rate_ratio),
    .rate_count (rate_count),
    .count_bcd  (count_bcd),
    .dir_down   (dir_down),
    .seg_bus    (seg_bus)
  );

  // Per-segment lit sets over values 0..15 (R9), bit v set = lit for value v.
  function automatic logic [6:0] exp_seg(input logic [3:0] v);
    logic [15:0] lit [7];
    logic [6:0] s;
    lit[0] = 16'hD7ED; lit[1] = 16'h279F; lit[2] = 16'h2FFB; lit[3] = 16'h7B6D;
    lit[4] = 16'hFD45; lit[5] = 16'hDF71; lit[6] = 16'hEF7C;
    for (int b = 0; b < 7; b++) s[b] = lit[b][v];
    return s;
  endfunction

  function automatic logic [7:0] to_bcd(input int n);
    return {4'(n / 10), 4'(n % 10)};
  endfunction

  task automatic check(input string tag, input string what, input logic [27:0] act, input logic [27:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Called at a negedge: drive, run one edge, check at the following negedge.
  task automatic step(input bit stb, input bit tgl, input bit pse, input bit sel,
                      input logic [3:0] ratio, input logic [3:0] cnt, input string tag);
    logic [27:0] es;
    logic [3:0] slot [2];
    cnt_stb = stb; dir_tgl = tgl; pause = pse; show_rate = sel;
    rate_ratio = ratio; rate_count = cnt;
    slot[0] = sel ? cnt   : 4'(ref_val % 10);
    slot[1] = sel ? ratio : 4'(ref_val / 10);
    for (int p = 0; p < 4; p++) es[p*7 +: 7] = exp_seg(slot[p/2]);
    if (stb && !pse) ref_val = ref_down ? (ref_val + 99) % 100 : (ref_val + 1) % 100;
    if (tgl) ref_down = !ref_down;
    @(posedge clk);
    @(negedge clk);
    check(tag, "count", 28'(count_bcd), 28'(to_bcd(ref_val)));
    check(tag, "dir", 28'(dir_down), 28'(ref_down));
    check(tag, "seg", seg_bus, es);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1", "count", 28'(count_bcd), 28'h0);
    check("R1", "dir", 28'(dir_down), 28'h0);
    check("R1", "seg", seg_bus, {4{7'h3F}});

    // R2 R3: full up sweep through 99 -> 00, interleaved idle cycles (R10)
    for (int i = 0; i < 205; i++) begin
      step(1, 0, 0, 0, 4'd0, 4'd0, "R2 R3");
      if (i % 17 == 0) step(0, 0, 0, 0, 4'd0, 4'd0, "R10");
    end

    // R5: toggle alone flips direction, count unchanged
    step(0, 1, 0, 0, 4'd0, 4'd0, "R5");

    // R4: full down sweep through 00 -> 99
    for (int i = 0; i < 205; i++) step(1, 0, 0, 0, 4'd0, 4'd0, "R4");

    // R6: toggle with strobe in the same cycle, crossing both wrap points
    for (int i = 0; i < 40; i++) begin
      step(1, (i % 3) == 0, 0, 0, 4'd0, 4'd0, "R6");
    end
    while (ref_val != 0) step(1, 0, 0, 0, 4'd0, 4'd0, "R6");
    step(1, 1, 0, 0, 4'd0, 4'd0, "R6");
    step(1, 1, 0, 0, 4'd0, 4'd0, "R6");

    // R7: pause with strobes and toggles
    for (int i = 0; i < 30; i++) begin
      step(1, (i % 4) == 1, 1, 0, 4'd0, 4'd0, "R7");
      if (i % 5 == 0) step(1, 0, 0, 0, 4'd0, 4'd0, "R7");
    end

    // R8 R9: alternate view over all ratio/count pairs, stepping alongside
    for (int r = 0; r < 16; r++) begin
      for (int c = 0; c < 16; c++) begin
        step(c[0], 0, 0, 1, 4'(r), 4'(c), "R8 R9");
      end
      step(1, 0, 0, 0, 4'(r), 4'd0, "R8");
    end

    finish_run();
  end

endmodule